// File: doc/BRIEF.md
# Asynchronous SRAM Bus Timing Monitor

A passive observer for the control pins of an asynchronous static RAM with two chip selects (one active low, one active high), an active-low output enable, an active-low write enable and two active-low byte strobes. Every pin is sampled on a fast reference clock. Interval rules are measured as run lengths in reference-clock ticks. The monitor drives nothing onto the memory bus and never stalls the controller. It has no streaming interface, so every port is a plain level.

Each sample is decoded into one of six access classes. A per-class counter advances when the decoded class changes. Six rule checkers watch the write pulse, the address cycle, the chip-select-to-end-of-write time, the address-to-end-of-write time, the data setup time and bus contention. Each rule owns one sticky flag bit. A synchronous clear input zeroes all flags and all class counters together. Two threshold sets are parameters, one for each speed grade. A single parameter selects which set is used.

A write is in progress while the device is selected, write enable is low and at least one byte strobe is low. The output enable level does not matter for this. The end of the write is the first sample at which that condition no longer holds. All write rules are judged on that sample.

Top module: `sram_bus_monitor`

## Requirements
- R1: The device is selected when `cs1_n`=0 and `cs2`=1. Classes are encoded as 0 deselect, 1 output-disabled, 2 byte read, 3 word read, 4 byte write and 5 word write. The decode is as follows:
  - Not selected gives deselect.
  - Selected with both strobes high gives output-disabled.
  - Selected with `we_n`=0 gives a write, whatever `oe_n` is. Exactly one strobe low makes it a byte write; both strobes low make it a word write.
  - Otherwise `oe_n`=1 gives output-disabled, and `oe_n`=0 gives a byte read or a word read by the same strobe rule.
  - Counter i is `cls_cnt[i*CNT_W +: CNT_W]`. It increments by one, saturating, in the cycle after a sample whose class differs from the previous sample's class. The class held before the first sample is deselect.
- R2: If a write lasted fewer than T_WP samples, flag bit 0 is set after the end-of-write sample.
- R3: Two address changes fewer than T_RC samples apart set flag bit 1 after the second change. The first change after reset is never flagged.
- R4: If the device was selected for fewer than T_CW consecutive samples up to the end of a write, flag bit 2 is set after the end-of-write sample.
- R5: If fewer than T_AW samples passed between the last address change and the end of a write, flag bit 3 is set after the end-of-write sample.
- R6: If `drv_en` was high for fewer than T_DW consecutive samples just before the end of a write, flag bit 4 is set after the end-of-write sample.
- R7: A sample with the device selected, `oe_n`=0, `we_n`=1 and `drv_en`=1 sets flag bit 5 in the next cycle. With `oe_n`=1 the same drive sets nothing.
- R8: Flags stay set until clear. When `clr` is high in a cycle, all flags and counters read zero in the next cycle.
- R9: With `SLOW_GRADE`=1 the slow thresholds apply: pulse 10, cycle 14, select 12, address 12, data 6. With `SLOW_GRADE`=0 the fast thresholds apply: 8, 11, 9, 9, 5.
- R10: After reset all flags and all counters are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Reference sampling clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| clr | input | 1 | Synchronous clear of flags and counters |
| cs1_n | input | 1 | Chip select, active low |
| cs2 | input | 1 | Chip select, active high |
| oe_n | input | 1 | Output enable, active low |
| we_n | input | 1 | Write enable, active low |
| ub_n | input | 1 | Upper byte strobe, active low |
| lb_n | input | 1 | Lower byte strobe, active low |
| addr | input | AW | Address bus |
| drv_en | input | 1 | Controller is driving the data bus |
| viol | output | 6 | Sticky rule flags, bit per rule (R2 to R7) |
| cls_cnt | output | 6*CNT_W | Per-class access counters |

## Verification
The bound assertions check the following on every cycle:
- flags are sticky, and clear empties the flags and counters;
- contention sets its flag;
- the four write-rule flags can change only after an end-of-write sample;
- the address-cycle flag can change only after an address change;
- the counter total grows by at most one per cycle.

Whether a given run length trips exactly the right rule at its threshold needs the bench's scenarios. The same holds for the full mode decode and the grade selection. Each scenario places a write just inside or just outside one limit and expects exactly one flag.

// File: rtl/sram_mon_pkg.sv
package sram_mon_pkg;
  typedef enum logic [2:0] {
    CLS_DESEL  = 3'd0,
    CLS_OUTDIS = 3'd1,
    CLS_BRD    = 3'd2,
    CLS_WRD    = 3'd3,
    CLS_BWR    = 3'd4,
    CLS_WWR    = 3'd5
  } acc_cls_e;

  localparam int NCLS  = 6;
  localparam int NRULE = 6;

  // rule flag positions
  localparam int RULE_WP  = 0;
  localparam int RULE_RC  = 1;
  localparam int RULE_CW  = 2;
  localparam int RULE_AW  = 3;
  localparam int RULE_DW  = 4;
  localparam int RULE_BUS = 5;
endpackage

// File: rtl/sram_mode_decode.sv
module sram_mode_decode
  import sram_mon_pkg::*;
(
  input  logic     cs1_n,
  input  logic     cs2,
  input  logic     oe_n,
  input  logic     we_n,
  input  logic     ub_n,
  input  logic     lb_n,
  output acc_cls_e cls,
  output logic     sel,
  output logic     wr_act,
  output logic     rd_drv
);
  logic any_b, both_b;

  assign sel    = !cs1_n && cs2;
  assign any_b  = !(ub_n && lb_n);
  assign both_b = !ub_n && !lb_n;
  assign wr_act = sel && !we_n && any_b;
  assign rd_drv = sel && !oe_n && we_n;

  always_comb begin
    if (!sel)       cls = CLS_DESEL;
    else if (!any_b) cls = CLS_OUTDIS;
    else if (!we_n)  cls = both_b ? CLS_WWR : CLS_BWR;
    else if (oe_n)   cls = CLS_OUTDIS;
    else             cls = both_b ? CLS_WRD : CLS_BRD;
  end
endmodule

// File: rtl/sram_run_timer.sv
module sram_run_timer #(
  parameter int W       = 6,
  parameter bit RST_SAT = 1'b0
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         restart,
  input  logic         hold,
  output logic [W-1:0] cnt
);
  localparam logic [W-1:0] RST_VAL = RST_SAT ? {W{1'b1}} : '0;

  logic [W-1:0] inc;
  assign inc = (cnt == {W{1'b1}}) ? cnt : cnt + 1'b1;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       cnt <= RST_VAL;
    else if (restart) cnt <= W'(1);
    else if (hold)    cnt <= inc;
    else              cnt <= '0;
  end
endmodule

// File: rtl/sram_class_counters.sv
module sram_class_counters
  import sram_mon_pkg::*;
#(
  parameter int CNT_W = 16
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  clr,
  input  acc_cls_e              cls,
  output logic [NCLS*CNT_W-1:0] cnt_flat
);
  acc_cls_e prev_q;
  logic     enter;

  assign enter = (cls != prev_q);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) prev_q <= CLS_DESEL;
    else        prev_q <= cls;
  end

  for (genvar i = 0; i < NCLS; i++) begin : g_cnt
    logic [CNT_W-1:0] c_q;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                                  c_q <= '0;
      else if (clr)                                c_q <= '0;
      else if (enter && (cls == acc_cls_e'(i)) && (c_q != {CNT_W{1'b1}}))
                                                   c_q <= c_q + 1'b1;
    end
    assign cnt_flat[i*CNT_W +: CNT_W] = c_q;
  end
endmodule

// File: rtl/sram_bus_monitor.sv
module sram_bus_monitor
  import sram_mon_pkg::*;
#(
  parameter int AW         = 21,
  parameter int CNT_W      = 16,
  parameter bit SLOW_GRADE = 1'b0,
  parameter int F_WP = 8,  parameter int S_WP = 10,
  parameter int F_RC = 11, parameter int S_RC = 14,
  parameter int F_CW = 9,  parameter int S_CW = 12,
  parameter int F_AW = 9,  parameter int S_AW = 12,
  parameter int F_DW = 5,  parameter int S_DW = 6
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  clr,
  input  logic                  cs1_n,
  input  logic                  cs2,
  input  logic                  oe_n,
  input  logic                  we_n,
  input  logic                  ub_n,
  input  logic                  lb_n,
  input  logic [AW-1:0]         addr,
  input  logic                  drv_en,
  output logic [NRULE-1:0]      viol,
  output logic [NCLS*CNT_W-1:0] cls_cnt
);
  localparam int T_WP = SLOW_GRADE ? S_WP : F_WP;
  localparam int T_RC = SLOW_GRADE ? S_RC : F_RC;
  localparam int T_CW = SLOW_GRADE ? S_CW : F_CW;
  localparam int T_AW = SLOW_GRADE ? S_AW : F_AW;
  localparam int T_DW = SLOW_GRADE ? S_DW : F_DW;
  localparam int T_M1 = (T_WP > T_RC) ? T_WP : T_RC;
  localparam int T_M2 = (T_CW > T_AW) ? T_CW : T_AW;
  localparam int T_M3 = (T_M1 > T_M2) ? T_M1 : T_M2;
  localparam int T_MX = (T_M3 > T_DW) ? T_M3 : T_DW;
  localparam int TW   = $clog2(T_MX + 1) + 1;

  acc_cls_e cls;
  logic     sel, wr_act, rd_drv;

  sram_mode_decode u_dec (
    .cs1_n(cs1_n), .cs2(cs2), .oe_n(oe_n), .we_n(we_n),
    .ub_n(ub_n), .lb_n(lb_n),
    .cls(cls), .sel(sel), .wr_act(wr_act), .rd_drv(rd_drv)
  );

  sram_class_counters #(.CNT_W(CNT_W)) u_cnt (
    .clk(clk), .rst_n(rst_n), .clr(clr), .cls(cls), .cnt_flat(cls_cnt)
  );

  // edge detection on address and write condition
  logic [AW-1:0] addr_q;
  logic          wr_q, a_chg, wr_end;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      addr_q <= '0;
      wr_q   <= 1'b0;
    end else begin
      addr_q <= addr;
      wr_q   <= wr_act;
    end
  end

  assign a_chg  = (addr != addr_q);
  assign wr_end = wr_q && !wr_act;

  // run-length timers: index 0 address age, 1 write, 2 select, 3 drive
  localparam int NT = 4;
  logic [NT-1:0] t_hold;
  logic [TW-1:0] t_val [NT];

  assign t_hold = {drv_en, sel, wr_act, 1'b1};

  for (genvar k = 0; k < NT; k++) begin : g_tmr
    sram_run_timer #(.W(TW), .RST_SAT(k == 0)) u_t (
      .clk(clk), .rst_n(rst_n),
      .restart((k == 0) ? a_chg : 1'b0),
      .hold(t_hold[k]),
      .cnt(t_val[k])
    );
  end

  logic [NRULE-1:0] hit;
  always_comb begin
    hit           = '0;
    hit[RULE_WP]  = wr_end && (t_val[1] < TW'(T_WP));
    hit[RULE_RC]  = a_chg  && (t_val[0] < TW'(T_RC));
    hit[RULE_CW]  = wr_end && (t_val[2] < TW'(T_CW));
    hit[RULE_AW]  = wr_end && (t_val[0] < TW'(T_AW));
    hit[RULE_DW]  = wr_end && (t_val[3] < TW'(T_DW));
    hit[RULE_BUS] = rd_drv && drv_en;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)   viol <= '0;
    else if (clr) viol <= '0;
    else          viol <= viol | hit;
  end
endmodule

// File: rtl/sram_bus_monitor_chk.sv
module sram_bus_monitor_chk
  import sram_mon_pkg::*;
#(
  parameter int AW    = 21,
  parameter int CNT_W = 16
) (
  input logic                  clk,
  input logic                  rst_n,
  input logic                  clr,
  input logic                  cs1_n,
  input logic                  cs2,
  input logic                  oe_n,
  input logic                  we_n,
  input logic                  ub_n,
  input logic                  lb_n,
  input logic [AW-1:0]         addr,
  input logic                  drv_en,
  input logic [NRULE-1:0]      viol,
  input logic [NCLS*CNT_W-1:0] cls_cnt
);
  logic          wr_now, wr_prev, end_ev;
  logic [AW-1:0] a_prev;
  logic [CNT_W+2:0] sum;

  assign wr_now = !cs1_n && cs2 && !we_n && !(ub_n && lb_n);
  assign end_ev = wr_prev && !wr_now;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_prev <= 1'b0;
      a_prev  <= '0;
    end else begin
      wr_prev <= wr_now;
      a_prev  <= addr;
    end
  end

  always_comb begin
    sum = '0;
    for (int i = 0; i < NCLS; i++) sum = sum + (CNT_W+3)'(cls_cnt[i*CNT_W +: CNT_W]);
  end

  // R8: set flags persist without clear
  p_sticky_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !clr |=> ((viol & $past(viol)) == $past(viol)));

  // R8: clear empties flags and counters
  p_clear_r8: assert property (@(posedge clk) disable iff (!rst_n)
    clr |=> (viol == '0 && cls_cnt == '0));

  // R7: contention raises its flag
  p_conflict_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (!clr && !cs1_n && cs2 && !oe_n && we_n && drv_en) |=> viol[RULE_BUS]);

  // R2 (also R4, R5, R6): write-rule flags move only after an end of write
  p_write_flags_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (!clr && !end_ev) |=> $stable({viol[RULE_DW], viol[RULE_AW], viol[RULE_CW], viol[RULE_WP]}));

  // R3: cycle flag moves only after an address change
  p_cycle_flag_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (!clr && addr == a_prev) |=> $stable(viol[RULE_RC]));

  // R1: at most one class counted per cycle
  p_one_class_r1: assert property (@(posedge clk) disable iff (!rst_n)
    !clr |=> (sum == $past(sum) || sum == $past(sum) + 1'b1));
endmodule

bind sram_bus_monitor sram_bus_monitor_chk #(.AW(AW), .CNT_W(CNT_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .clr(clr), .cs1_n(cs1_n), .cs2(cs2),
  .oe_n(oe_n), .we_n(we_n), .ub_n(ub_n), .lb_n(lb_n), .addr(addr),
  .drv_en(drv_en), .viol(viol), .cls_cnt(cls_cnt)
);

// File: tb/sim_sram_bus_monitor.sv
module sim_sram_bus_monitor;
  localparam int AW    = 21;
  localparam int CNT_W = 16;
  localparam int NC    = 6;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic clr = 1'b0;
  logic cs1_n = 1'b1, cs2 = 1'b1, oe_n = 1'b1, we_n = 1'b1, ub_n = 1'b1, lb_n = 1'b1;
  logic drv_en = 1'b0;
  logic [AW-1:0] addr = '0;
  logic [AW-1:0] cur_addr = '0;
  logic [5:0] viol, viol_s;
  logic [NC*CNT_W-1:0] cnt, cnt_s;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #10 clk = ~clk; // 50 MHz

  sram_bus_monitor #(.AW(AW), .CNT_W(CNT_W), .SLOW_GRADE(1'b0)) u0 (
    .clk(clk), .rst_n(rst_n), .clr(clr), .cs1_n(cs1_n), .cs2(cs2),
    .oe_n(oe_n), .we_n(we_n), .ub_n(ub_n), .lb_n(lb_n), .addr(addr),
    .drv_en(drv_en), .viol(viol), .cls_cnt(cnt)
  );

  sram_bus_monitor #(.AW(AW), .CNT_W(CNT_W), .SLOW_GRADE(1'b1)) u1 (
    .clk(clk), .rst_n(rst_n), .clr(clr), .cs1_n(cs1_n), .cs2(cs2),
    .oe_n(oe_n), .we_n(we_n), .ub_n(ub_n), .lb_n(lb_n), .addr(addr),
    .drv_en(drv_en), .viol(viol_s), .cls_cnt(cnt_s)
  );

  // {cs1_n,cs2,oe_n,we_n,ub_n,lb_n, class}
  localparam logic [8:0] VEC [12] = '{
    {6'b011110, 3'd1}, {6'b010110, 3'd2}, {6'b100000, 3'd0},
    {6'b010101, 3'd2}, {6'b010100, 3'd3}, {6'b000000, 3'd0},
    {6'b011010, 3'd4}, {6'b010000, 3'd5}, {6'b010011, 3'd1},
    {6'b011001, 3'd4}, {6'b110000, 3'd0}, {6'b010100, 3'd3}
  };

  task automatic chk(input string req, input logic [127:0] act, input logic [127:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic smp(input logic c1n, input logic c2, input logic oen, input logic wen,
                     input logic ubn, input logic lbn, input logic [AW-1:0] a, input logic d);
    cs1_n = c1n; cs2 = c2; oe_n = oen; we_n = wen; ub_n = ubn; lb_n = lbn;
    addr = a; drv_en = d;
    @(negedge clk);
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) smp(1, 1, 1, 1, 1, 1, cur_addr, 0);
  endtask

  task automatic clear_all();
    idle(20);
    clr = 1'b1;
    idle(1);
    clr = 1'b0;
  endtask

  // write scenario: address changes at offset achg (negative = before select),
  // select for pre samples with we_n high, then wp samples with we_n low,
  // drv_en high for the last dw samples of the select window
  task automatic wcycle(input int achg, input int pre, input int wp, input int dw,
                        input logic [AW-1:0] na);
    int len;
    int ts;
    len = pre + wp;
    ts  = (achg < 0) ? achg : 0;
    for (int t = ts; t < len; t++)
      smp(t < 0, 1, 1, !(t >= pre), t < 0, t < 0, (t >= achg) ? na : cur_addr, t >= len - dw);
    cur_addr = na;
    smp(1, 1, 1, 1, 1, 1, cur_addr, 0);
  endtask

  initial begin
    #(20 * 200000);
    errors++;
    checks++;
    $display("FAIL watchdog actual=running expected=finished");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    int mc [NC];
    int prev;
    for (int i = 0; i < NC; i++) mc[i] = 0;
    prev = 0;

    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R10 flags after reset", 128'(viol), 128'(0));
    chk("R10 counters after reset", 128'(cnt), 128'(0));

    // R1 mode table walk
    for (int v = 0; v < 12; v++) begin
      logic [8:0] e;
      logic [NC*CNT_W-1:0] expc;
      e = VEC[v];
      smp(e[8], e[7], e[6], e[5], e[4], e[3], cur_addr, 0);
      if (int'(e[2:0]) != prev) mc[e[2:0]]++;
      prev = int'(e[2:0]);
      for (int i = 0; i < NC; i++) expc[i*CNT_W +: CNT_W] = CNT_W'(mc[i]);
      chk($sformatf("R1 class counters row %0d", v), 128'(cnt), 128'(expc));
    end

    // R8 clear empties counters and flags
    idle(1);
    clr = 1'b1; idle(1); clr = 1'b0;
    chk("R8 counters after clear", 128'(cnt), 128'(0));
    chk("R8 flags after clear", 128'(viol), 128'(0));

    // legal write (fast) / slow grade flags R9
    clear_all();
    wcycle(0, 4, 8, 5, 21'h00010);
    chk("R2 legal write no flag", 128'(viol), 128'(0));
    chk("R9 slow grade pulse and data", 128'(viol_s), 128'(6'b010001));

    clear_all();
    wcycle(0, 4, 7, 5, 21'h00020);
    chk("R2 short write pulse", 128'(viol), 128'(6'b000001));

    clear_all();
    wcycle(-3, 0, 8, 5, 21'h00030);
    chk("R4 short select to end", 128'(viol), 128'(6'b000100));

    clear_all();
    wcycle(3, 3, 8, 5, 21'h00040);
    chk("R5 short address to end", 128'(viol), 128'(6'b001000));

    clear_all();
    wcycle(0, 4, 8, 4, 21'h00050);
    chk("R6 short data setup", 128'(viol), 128'(6'b010000));

    // R3 address cycle: 10 apart flags, 11 apart passes
    clear_all();
    cur_addr = 21'h00100; idle(10);
    cur_addr = 21'h00101; idle(1);
    chk("R3 address gap 10", 128'(viol), 128'(6'b000010));
    clear_all();
    cur_addr = 21'h00200; idle(11);
    cur_addr = 21'h00201; idle(1);
    chk("R3 address gap 11", 128'(viol), 128'(0));

    // R7 contention
    clear_all();
    smp(0, 1, 1, 1, 0, 0, cur_addr, 1);
    chk("R7 drive with output disabled", 128'(viol), 128'(0));
    smp(0, 1, 0, 1, 0, 0, cur_addr, 1);
    chk("R7 drive during read", 128'(viol), 128'(6'b100000));
    idle(5);
    chk("R8 flag stays set", 128'(viol), 128'(6'b100000));

    // R1 write enable low with no strobe is not a write
    clear_all();
    for (int i = 0; i < 3; i++) smp(0, 1, 1, 0, 1, 1, cur_addr, 0);
    idle(1);
    chk("R1 no strobe no write flags", 128'(viol), 128'(0));

    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule